// File: doc/BRIEF.md
# AXI4-Lite Register Slave with Write Counter

This block is a memory-mapped slave on an AXI4-Lite bus. It holds a small register file of 32-bit words. Two general registers can be written and read back. One read-only word shows the live value of a hardware status input. A statistics word counts every write transaction the slave completes, whatever address that write targets.

The write side and the read side run on their own. The slave takes the write address and the write data each on its own handshake, in either order or in the same cycle. It commits the write and raises the write response only once it holds both. A read takes its data from the register file in the cycle of its address handshake and returns it on the read data channel.

Every response is OKAY. Unmapped offsets read as zero and absorb writes.

Top module: `axlr_slave`

## Requirements
- R1: After reset every general register and the write counter read zero, and `b_valid_o` and `r_valid_o` are low.
- R2: The general registers at byte offsets 0x00 and 0x04 return on a read the value last written to them.
- R3: In a write to a general register, bit i of `w_strb_i` enables the update of data bits [8i+7:8i]. A byte whose strobe bit is 0 keeps its old value.
- R4: A read of offset 0x08 returns the value `hw_status_i` has in the cycle of the read address handshake.
- R5: The counter at offset 0x10 (held in the low bits, upper bits zero) adds exactly one for each completed write transaction to any offset, including 0x08, 0x10 and unmapped offsets. It does not change otherwise.
- R6: Writes to offsets 0x08 and 0x10 change no stored value and receive `b_resp_o` = 2'b00 (OKAY).
- R7: A read of an unmapped offset (0x0C, 0x14, 0x18, 0x1C) returns zero with `r_resp_o` = 2'b00 (OKAY).
- R8: The write address and write data are each accepted on their own handshake, in either order. `b_valid_o` stays low until both have been accepted.
- R9: Once raised, `b_valid_o` and `r_valid_o` stay high until the matching ready is seen high at a clock edge. `r_data_o` is stable while `r_valid_o` waits.
- R10: A read completes while a write is pending with its address accepted and its data not yet given. The pending write does not change the counter or the registers before it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_addr_i | input | 5 | Write address (byte offset) |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| w_data_i | input | 32 | Write data |
| w_strb_i | input | 4 | Write byte strobes |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| b_resp_o | output | 2 | Write response, always OKAY |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| ar_addr_i | input | 5 | Read address (byte offset) |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready |
| r_data_o | output | 32 | Read data |
| r_resp_o | output | 2 | Read response, always OKAY |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| hw_status_i | input | 32 | Live hardware status shown at offset 0x08 |

## Verification
The hardest case to reach from the ports is a write left half-done: its address has been taken but its data is held back. This is the window in which a read must still complete and the counter must not yet move. The bench reaches it by driving the address and data channels from separate tasks with idle cycles between them. It runs a read of a general register and a read of the counter inside that gap, before the data is given. The same split-channel tasks also drive the data before the address, to show that no response appears until the second handshake.

// File: rtl/axlr_pkg.sv
package axlr_pkg;
   typedef logic [1:0] resp_t;
   localparam resp_t RESP_OKAY = 2'b00;
   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/axlr_wr_chan.sv
module axlr_wr_chan #(
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [IDX_W-1:0]  aw_idx_i,
   input  logic              aw_valid_i,
   output logic              aw_ready_o,
   input  logic [DATA_W-1:0] w_data_i,
   input  logic [STRB_W-1:0] w_strb_i,
   input  logic              w_valid_i,
   output logic              w_ready_o,
   output logic              b_valid_o,
   input  logic              b_ready_i,
   output logic              commit_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [DATA_W-1:0] data_o,
   output logic [STRB_W-1:0] strb_o
);
   logic aw_held_q, w_held_q, b_valid_q;

   assign aw_ready_o = !aw_held_q && !b_valid_q;
   assign w_ready_o  = !w_held_q && !b_valid_q;
   assign commit_o   = aw_held_q && w_held_q;
   assign b_valid_o  = b_valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         aw_held_q <= 1'b0;
         w_held_q  <= 1'b0;
         b_valid_q <= 1'b0;
         idx_o     <= '0;
         data_o    <= '0;
         strb_o    <= '0;
      end else begin
         if (aw_valid_i && aw_ready_o) begin
            idx_o     <= aw_idx_i;
            aw_held_q <= 1'b1;
         end
         if (w_valid_i && w_ready_o) begin
            data_o   <= w_data_i;
            strb_o   <= w_strb_i;
            w_held_q <= 1'b1;
         end
         if (commit_o) begin
            aw_held_q <= 1'b0;
            w_held_q  <= 1'b0;
            b_valid_q <= 1'b1;
         end else if (b_valid_q && b_ready_i) begin
            b_valid_q <= 1'b0;
         end
      end
   end

   AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_valid_o && !b_ready_i |=> b_valid_o); // R9
   AST_B_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(b_valid_o) |-> $past(aw_held_q && w_held_q)); // R8
endmodule

// File: rtl/axlr_regfile.sv
module axlr_regfile #(
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned STRB_W   = DATA_W / 8,
   parameter int unsigned NUM_RW   = 2,
   parameter int unsigned STAT_OFS = 8,
   parameter int unsigned CNT_OFS  = 16,
   parameter int unsigned CNT_W    = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [STRB_W-1:0] wr_strb_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   input  logic [DATA_W-1:0] status_i,
   output logic [DATA_W-1:0] rd_data_o
);
   import axlr_pkg::*;

   localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(STAT_OFS / 4);
   localparam logic [IDX_W-1:0] CNT_IDX  = IDX_W'(CNT_OFS / 4);

   logic [NUM_RW-1:0][DATA_W-1:0] rw_vals;
   logic [CNT_W-1:0]              cnt_q;

   for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
      logic [DATA_W-1:0] val_q;
      logic              sel;
      assign sel        = wr_en_i && (wr_idx_i == IDX_W'(g));
      assign rw_vals[g] = val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            val_q <= '0;
         end else if (sel) begin
            for (int b = 0; b < STRB_W; b++) begin
               if (wr_strb_i[b]) val_q[b*BYTE_W +: BYTE_W] <= wr_data_i[b*BYTE_W +: BYTE_W];
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (wr_en_i) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM_RW; i++) begin
         if (rd_idx_i == IDX_W'(i)) rd_data_o = rw_vals[i];
      end
      if (rd_idx_i == STAT_IDX) rd_data_o = status_i;
      if (rd_idx_i == CNT_IDX)  rd_data_o = DATA_W'(cnt_q);
   end

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R5
   AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(cnt_q)); // R5
   AST_RO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && (wr_idx_i >= IDX_W'(NUM_RW)) |=> $stable(rw_vals)); // R6
endmodule

// File: rtl/axlr_rd_chan.sv
module axlr_rd_chan #(
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [IDX_W-1:0]  ar_idx_i,
   input  logic              ar_valid_i,
   output logic              ar_ready_o,
   output logic [IDX_W-1:0]  rd_idx_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] r_data_o,
   output logic              r_valid_o,
   input  logic              r_ready_i
);
   assign ar_ready_o = !r_valid_o;
   assign rd_idx_o   = ar_idx_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         r_valid_o <= 1'b0;
         r_data_o  <= '0;
      end else if (ar_valid_i && ar_ready_o) begin
         r_valid_o <= 1'b1;
         r_data_o  <= rd_data_i;
      end else if (r_valid_o && r_ready_i) begin
         r_valid_o <= 1'b0;
      end
   end

   AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r_valid_o && !r_ready_i |=> r_valid_o); // R9
   AST_R_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r_valid_o && !r_ready_i |=> $stable(r_data_o)); // R9
endmodule

// File: rtl/axlr_slave.sv
module axlr_slave #(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_RW   = 2,
   parameter int unsigned STAT_OFS = 8,
   parameter int unsigned CNT_OFS  = 16,
   parameter int unsigned CNT_W    = 32,
   localparam int unsigned STRB_W  = DATA_W / 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ADDR_W-1:0]    aw_addr_i,
   input  logic                 aw_valid_i,
   output logic                 aw_ready_o,
   input  logic [DATA_W-1:0]    w_data_i,
   input  logic [STRB_W-1:0]    w_strb_i,
   input  logic                 w_valid_i,
   output logic                 w_ready_o,
   output logic [1:0]           b_resp_o,
   output logic                 b_valid_o,
   input  logic                 b_ready_i,
   input  logic [ADDR_W-1:0]    ar_addr_i,
   input  logic                 ar_valid_i,
   output logic                 ar_ready_o,
   output logic [DATA_W-1:0]    r_data_o,
   output logic [1:0]           r_resp_o,
   output logic                 r_valid_o,
   input  logic                 r_ready_i,
   input  logic [DATA_W-1:0]    hw_status_i
);
   import axlr_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 2;

   initial begin
      assert (DATA_W == 32) else $error("axlr_slave: DATA_W must be 32");
      assert (NUM_RW >= 2) else $error("axlr_slave: need two or more general registers");
      assert (NUM_RW * 4 <= STAT_OFS) else $error("axlr_slave: status overlaps general registers");
      assert (STAT_OFS < CNT_OFS) else $error("axlr_slave: counter must sit above status");
      assert (CNT_OFS < (1 << ADDR_W)) else $error("axlr_slave: counter outside address space");
      assert (CNT_W >= 1 && CNT_W <= DATA_W) else $error("axlr_slave: bad counter width");
   end

   logic              unused_low_bits;
   logic              commit;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic [STRB_W-1:0] wr_strb;

   assign unused_low_bits = ^{aw_addr_i[1:0], ar_addr_i[1:0]};
   assign b_resp_o = RESP_OKAY;
   assign r_resp_o = RESP_OKAY;

   axlr_wr_chan #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) wr_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .aw_idx_i(aw_addr_i[ADDR_W-1:2]), .aw_valid_i(aw_valid_i), .aw_ready_o(aw_ready_o),
      .w_data_i(w_data_i), .w_strb_i(w_strb_i), .w_valid_i(w_valid_i), .w_ready_o(w_ready_o),
      .b_valid_o(b_valid_o), .b_ready_i(b_ready_i),
      .commit_o(commit), .idx_o(wr_idx), .data_o(wr_data), .strb_o(wr_strb));

   axlr_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STRB_W(STRB_W), .NUM_RW(NUM_RW),
                  .STAT_OFS(STAT_OFS), .CNT_OFS(CNT_OFS), .CNT_W(CNT_W)) rf_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(commit), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
      .rd_idx_i(rd_idx), .status_i(hw_status_i), .rd_data_o(rd_data));

   axlr_rd_chan #(.IDX_W(IDX_W), .DATA_W(DATA_W)) rd_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ar_idx_i(ar_addr_i[ADDR_W-1:2]), .ar_valid_i(ar_valid_i), .ar_ready_o(ar_ready_o),
      .rd_idx_o(rd_idx), .rd_data_i(rd_data),
      .r_data_o(r_data_o), .r_valid_o(r_valid_o), .r_ready_i(r_ready_i));

   AST_RESP_OKAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_valid_o |-> b_resp_o == RESP_OKAY); // R6
endmodule

// File: tb/axlr_slave_tb.sv
module axlr_slave_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  aw_addr = '0, ar_addr = '0;
   logic        aw_valid = 0, w_valid = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
   logic [31:0] w_data = '0, hw_status = '0;
   logic [3:0]  w_strb = '0;
   logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
   logic [1:0]  b_resp, r_resp;
   logic [31:0] r_data;

   int checks = 0, errors = 0;
   logic [31:0] exp_rw [2];
   logic [31:0] exp_cnt = '0;
   bit done = 0;

   always #10 clk = ~clk;

   axlr_slave dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .aw_addr_i(aw_addr), .aw_valid_i(aw_valid), .aw_ready_o(aw_ready),
      .w_data_i(w_data), .w_strb_i(w_strb), .w_valid_i(w_valid), .w_ready_o(w_ready),
      .b_resp_o(b_resp), .b_valid_o(b_valid), .b_ready_i(b_ready),
      .ar_addr_i(ar_addr), .ar_valid_i(ar_valid), .ar_ready_o(ar_ready),
      .r_data_o(r_data), .r_resp_o(r_resp), .r_valid_o(r_valid), .r_ready_i(r_ready),
      .hw_status_i(hw_status));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic send_aw(input logic [4:0] a);
      aw_addr = a; aw_valid = 1;
      while (!aw_ready) @(negedge clk);
      @(negedge clk); aw_valid = 0;
   endtask

   task automatic send_w(input logic [31:0] d, input logic [3:0] s);
      w_data = d; w_strb = s; w_valid = 1;
      while (!w_ready) @(negedge clk);
      @(negedge clk); w_valid = 0;
   endtask

   task automatic get_b(input string tag);
      b_ready = 1;
      while (!b_valid) @(negedge clk);
      chk(tag, {30'd0, b_resp}, 32'd0);
      @(negedge clk); b_ready = 0;
      exp_cnt++;
   endtask

   task automatic send_ar(input logic [4:0] a);
      ar_addr = a; ar_valid = 1;
      while (!ar_ready) @(negedge clk);
      @(negedge clk); ar_valid = 0;
   endtask

   task automatic read_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
      send_ar(a);
      r_ready = 1;
      while (!r_valid) @(negedge clk);
      chk(tag, r_data, exp);
      chk({tag, " resp"}, {30'd0, r_resp}, 32'd0);
      @(negedge clk); r_ready = 0;
   endtask

   task automatic write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s, input string tag);
      fork
         send_aw(a);
         send_w(d, s);
      join
      get_b(tag);
   endtask

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] m = old;
      for (int b = 0; b < 4; b++) if (s[b]) m[b*8 +: 8] = d[b*8 +: 8];
      return m;
   endfunction

   task automatic t_reset();
      chk("R1 b_valid", {31'd0, b_valid}, 0);
      chk("R1 r_valid", {31'd0, r_valid}, 0);
      read_chk(5'h00, 0, "R1 reg0");
      read_chk(5'h04, 0, "R1 reg1");
      read_chk(5'h10, 0, "R1 counter");
   endtask

   task automatic t_rw();
      write(5'h00, 32'hDEADBEEF, 4'hF, "R2 wr0"); exp_rw[0] = 32'hDEADBEEF;
      write(5'h04, 32'h12345678, 4'hF, "R2 wr1"); exp_rw[1] = 32'h12345678;
      read_chk(5'h00, exp_rw[0], "R2 reg0");
      read_chk(5'h04, exp_rw[1], "R2 reg1");
      read_chk(5'h10, exp_cnt, "R5 count after two writes");
   endtask

   task automatic t_strb();
      write(5'h00, 32'hAABBCCDD, 4'b0101, "R3 wr");
      exp_rw[0] = merge(exp_rw[0], 32'hAABBCCDD, 4'b0101);
      read_chk(5'h00, exp_rw[0], "R3 strb 0101");
      write(5'h04, 32'h99887766, 4'b1000, "R3 wr");
      exp_rw[1] = merge(exp_rw[1], 32'h99887766, 4'b1000);
      read_chk(5'h04, exp_rw[1], "R3 strb 1000");
      write(5'h04, 32'hFFFFFFFF, 4'b0000, "R3 wr");
      read_chk(5'h04, exp_rw[1], "R3 strb 0000");
   endtask

   task automatic t_status();
      hw_status = 32'h0BADF00D;
      read_chk(5'h08, 32'h0BADF00D, "R4 status a");
      hw_status = 32'h13572468;
      read_chk(5'h08, 32'h13572468, "R4 status b");
   endtask

   task automatic t_ro_write();
      write(5'h08, 32'hFFFF0000, 4'hF, "R6 status wr resp");
      read_chk(5'h08, hw_status, "R6 status unchanged");
      write(5'h10, 32'h00000000, 4'hF, "R6 counter wr resp");
      read_chk(5'h10, exp_cnt, "R5 R6 counter counts ro write");
      read_chk(5'h00, exp_rw[0], "R6 reg0 untouched");
      read_chk(5'h04, exp_rw[1], "R6 reg1 untouched");
   endtask

   task automatic t_unmapped();
      write(5'h18, 32'h55555555, 4'hF, "R5 unmapped wr resp");
      read_chk(5'h10, exp_cnt, "R5 counter after unmapped write");
      read_chk(5'h0C, 0, "R7 read 0x0C");
      read_chk(5'h14, 0, "R7 read 0x14");
      read_chk(5'h18, 0, "R7 read 0x18");
      read_chk(5'h1C, 0, "R7 read 0x1C");
      read_chk(5'h00, exp_rw[0], "R7 reg0 untouched");
   endtask

   task automatic t_order();
      send_aw(5'h00);
      repeat (3) @(negedge clk);
      chk("R8 no b before w", {31'd0, b_valid}, 0);
      send_w(32'h01020304, 4'hF);
      get_b("R8 aw first");
      exp_rw[0] = 32'h01020304;
      read_chk(5'h00, exp_rw[0], "R8 aw first data");
      send_w(32'hA0B0C0D0, 4'hF);
      repeat (3) @(negedge clk);
      chk("R8 no b before aw", {31'd0, b_valid}, 0);
      send_aw(5'h04);
      get_b("R8 w first");
      exp_rw[1] = 32'hA0B0C0D0;
      read_chk(5'h04, exp_rw[1], "R8 w first data");
   endtask

   task automatic t_hold();
      logic [31:0] d0;
      hw_status = 32'hCAFE0001;
      send_ar(5'h08);
      while (!r_valid) @(negedge clk);
      d0 = r_data;
      hw_status = 32'h00000000;
      repeat (4) @(negedge clk);
      chk("R9 r_valid held", {31'd0, r_valid}, 1);
      chk("R9 r_data stable", r_data, d0);
      chk("R9 r_data value", r_data, 32'hCAFE0001);
      r_ready = 1; @(negedge clk); r_ready = 0;
      chk("R9 r_valid drops", {31'd0, r_valid}, 0);
      fork
         send_aw(5'h14);
         send_w(32'h0, 4'hF);
      join
      while (!b_valid) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R9 b_valid held", {31'd0, b_valid}, 1);
      get_b("R9 b resp");
      chk("R9 b_valid drops", {31'd0, b_valid}, 0);
   endtask

   task automatic t_indep();
      send_aw(5'h04);
      read_chk(5'h04, exp_rw[1], "R10 read during pending write");
      read_chk(5'h10, exp_cnt, "R10 counter before data");
      send_w(32'h7E7E7E7E, 4'hF);
      get_b("R10 completes");
      exp_rw[1] = 32'h7E7E7E7E;
      read_chk(5'h04, exp_rw[1], "R10 write landed");
      read_chk(5'h10, exp_cnt, "R10 R5 counter after");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_strb();
      t_status();
      t_ro_write();
      t_unmapped();
      t_order();
      t_hold();
      t_indep();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end
endmodule